// File: doc/BRIEF.md
# Shared Buffer Access Rights Manager

This block hands out access rights to shared data buffers that tasks create and destroy at run time. Each buffer is named by a data identifier. Behind each identifier sits one table entry holding the buffer's base page, a write lock with the identity of the writing task, a count of active readers and a count of consumers that must still free the buffer. Storage comes from a pool of fixed-size pages, one page per buffer.

Several requesters share the block. Each presents an operation (allocate, acquire for write, acquire for read, release, free) with a task identifier and a data identifier, and holds it until a one-cycle response comes back on its own port. An acquire that cannot be granted gets no answer; it waits and is reconsidered every cycle. Data coherence comes only from the exclusive write right, so there is no snooping. A buffer disappears only when its last consumer frees it, never because some task has ended.

Top module: `buf_rights_mgr`

## Requirements
- R1: ALLOC (op 0) of an identifier not in the table takes a free entry and the lowest-numbered free page and answers GRANT (code 0) with that page on rsp_page; ALLOC of an identifier already present answers GRANT with the existing page and consumes no page.
- R2: ALLOC of a new identifier when no entry or no page is free answers ERR_NO_SPACE (code 2).
- R3: ACQ_WR (op 1), ACQ_RD (op 2), RELEASE (op 3) or FREE (op 4) naming an identifier not in the table, and any op code 5 to 7, answers ERR_NO_ENTRY (code 1).
- R4: ACQ_WR is granted only when the buffer has no writer and no active reader; until then the requester receives no response, and it is granted in the cycle after the blocking right is given up, if no higher-priority requester is served then.
- R5: ACQ_RD is granted whenever the buffer has no writer, so several tasks hold read rights at once; each read grant also adds one consumer.
- R6: RELEASE by the task holding the write right clears it; otherwise, if readers are active, it removes one reader; otherwise it answers ERR_NOT_HOLDER (code 3). Reader identity is not tracked.
- R7: ALLOC sets the consumer count to one. FREE while more than one consumer remains only decrements the count and answers GRANT, leaving the buffer usable; FREE by the last consumer removes the entry and returns its page to the pool.
- R8: At most one request is answered per cycle; among requests that can complete, the lowest port index wins, and a blocked request never delays one on another port.
- R9: After reset no response is pending and the table and page pool are empty.
- R10: A request that can complete and wins arbitration is answered one cycle after it is presented; a port is never answered in two consecutive cycles; for any response on an existing or newly made buffer rsp_page holds its base page, otherwise 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NREQ | Per-port request present, held until answered |
| req_op | input | 3*NREQ | Per-port operation code, port i at bits [3i+2:3i] |
| req_task | input | TIDW*NREQ | Per-port task identifier |
| req_did | input | DIDW*NREQ | Per-port data identifier |
| rsp_valid | output | NREQ | One-cycle response strobe per port |
| rsp_code | output | 2 | Response code of the answered port |
| rsp_page | output | PGW | Base page returned with the response |

## Verification
The collisions that matter are two requests arriving in the same cycle and a right being given up in the cycle a blocked acquire is waiting for it. The bench launches requests on different ports in the same cycle and judges the order and latency of the answers against the fixed priority, including a case where a blocked write on port 0 must not hold back reads on ports 2 and 3. It also parks a write behind a held right, releases that right from another port, and expects the write to be answered only after the release.

// File: rtl/buf_rights_pkg.sv
package buf_rights_pkg;
  typedef enum logic [2:0] {
    OP_ALLOC  = 3'd0,
    OP_ACQ_WR = 3'd1,
    OP_ACQ_RD = 3'd2,
    OP_REL    = 3'd3,
    OP_FREE   = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    RSP_GRANT    = 2'd0,
    RSP_NO_ENTRY = 2'd1,
    RSP_NO_SPACE = 2'd2,
    RSP_NOT_HOLD = 2'd3
  } rsp_e;
endpackage

// File: rtl/buf_rights_lookup.sv
module buf_rights_lookup #(
  parameter int NENT = 16,
  parameter int DIDW = 8,
  localparam int EW = $clog2(NENT)
) (
  input  logic [NENT-1:0]      vld,
  input  logic [NENT*DIDW-1:0] dids,
  input  logic [DIDW-1:0]      key,
  output logic                 hit,
  output logic [EW-1:0]        idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int e = NENT - 1; e >= 0; e--) begin
      if (vld[e] && dids[e*DIDW +: DIDW] == key) begin
        hit = 1'b1;
        idx = EW'(e);
      end
    end
  end
endmodule

// File: rtl/buf_rights_first.sv
module buf_rights_first #(
  parameter int W = 16,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  bits,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int e = W - 1; e >= 0; e--) begin
      if (bits[e]) begin
        found = 1'b1;
        idx   = IW'(e);
      end
    end
  end
endmodule

// File: rtl/buf_rights_mgr.sv
module buf_rights_mgr
  import buf_rights_pkg::*;
#(
  parameter int NREQ  = 4,
  parameter int NENT  = 16,
  parameter int NPAGE = 16,
  parameter int TIDW  = 8,
  parameter int DIDW  = 8,
  parameter int CNTW  = 8,
  localparam int EW  = $clog2(NENT),
  localparam int PGW = $clog2(NPAGE),
  localparam int RW  = $clog2(NREQ)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NREQ-1:0]      req_valid,
  input  logic [3*NREQ-1:0]    req_op,
  input  logic [TIDW*NREQ-1:0] req_task,
  input  logic [DIDW*NREQ-1:0] req_did,
  output logic [NREQ-1:0]      rsp_valid,
  output logic [1:0]           rsp_code,
  output logic [PGW-1:0]       rsp_page
);
  // rights table
  logic [NENT-1:0]      ent_vld;
  logic [NENT-1:0]      ent_wr;
  logic [NENT*DIDW-1:0] ent_did;
  logic [TIDW-1:0]      ent_wtask [NENT];
  logic [PGW-1:0]       ent_page  [NENT];
  logic [CNTW-1:0]      ent_rd    [NENT];
  logic [CNTW-1:0]      ent_cons  [NENT];
  logic [NPAGE-1:0]     page_used;
  logic [NENT-1:0]      rd_busy;

  always_comb
    for (int e = 0; e < NENT; e++) rd_busy[e] = ent_vld[e] && (ent_rd[e] != '0);

  // per-port lookup
  logic [NREQ-1:0] hit;
  logic [EW-1:0]   hidx [NREQ];

  for (genvar g = 0; g < NREQ; g++) begin : g_look
    buf_rights_lookup #(.NENT(NENT), .DIDW(DIDW)) u_look (
      .vld (ent_vld),
      .dids(ent_did),
      .key (req_did[g*DIDW +: DIDW]),
      .hit (hit[g]),
      .idx (hidx[g])
    );
  end

  // a request can complete unless it is an acquire held back by a right
  logic [NREQ-1:0] ready;
  always_comb begin
    for (int i = 0; i < NREQ; i++) begin
      logic blk;
      blk = 1'b0;
      case (op_e'(req_op[i*3 +: 3]))
        OP_ACQ_WR: blk = hit[i] && (ent_wr[hidx[i]] || ent_rd[hidx[i]] != '0);
        OP_ACQ_RD: blk = hit[i] && ent_wr[hidx[i]];
        default:   blk = 1'b0;
      endcase
      ready[i] = req_valid[i] && !rsp_valid[i] && !blk;
    end
  end

  logic          sel_any;
  logic [RW-1:0] sel;
  logic          efree_any, pfree_any;
  logic [EW-1:0] efree;
  logic [PGW-1:0] pfree;

  buf_rights_first #(.W(NREQ))  u_arb  (.bits(ready),      .found(sel_any),   .idx(sel));
  buf_rights_first #(.W(NENT))  u_efre (.bits(~ent_vld),   .found(efree_any), .idx(efree));
  buf_rights_first #(.W(NPAGE)) u_pfre (.bits(~page_used), .found(pfree_any), .idx(pfree));

  op_e             s_op;
  logic [TIDW-1:0] s_task;
  logic [DIDW-1:0] s_did;
  logic            s_hit;
  logic [EW-1:0]   s_e;
  always_comb begin
    s_op   = op_e'(req_op[sel*3 +: 3]);
    s_task = req_task[sel*TIDW +: TIDW];
    s_did  = req_did[sel*DIDW +: DIDW];
    s_hit  = hit[sel];
    s_e    = hidx[sel];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ent_vld   <= '0;
      ent_wr    <= '0;
      ent_did   <= '0;
      page_used <= '0;
      rsp_valid <= '0;
      rsp_code  <= '0;
      rsp_page  <= '0;
      for (int e = 0; e < NENT; e++) begin
        ent_wtask[e] <= '0;
        ent_page[e]  <= '0;
        ent_rd[e]    <= '0;
        ent_cons[e]  <= '0;
      end
    end else begin
      rsp_valid <= '0;
      if (sel_any) begin
        rsp_valid[sel] <= 1'b1;
        rsp_page       <= s_hit ? ent_page[s_e] : '0;
        rsp_code       <= RSP_GRANT;
        if (!s_hit && s_op != OP_ALLOC) begin
          rsp_code <= RSP_NO_ENTRY;
        end else begin
          case (s_op)
            OP_ALLOC: begin
              if (!s_hit) begin
                if (efree_any && pfree_any) begin
                  ent_vld[efree]                <= 1'b1;
                  ent_wr[efree]                 <= 1'b0;
                  ent_did[efree*DIDW +: DIDW]   <= s_did;
                  ent_page[efree]               <= pfree;
                  ent_rd[efree]                 <= '0;
                  ent_cons[efree]               <= CNTW'(1);
                  page_used[pfree]              <= 1'b1;
                  rsp_page                      <= pfree;
                end else begin
                  rsp_code <= RSP_NO_SPACE;
                end
              end
            end
            OP_ACQ_WR: begin
              ent_wr[s_e]    <= 1'b1;
              ent_wtask[s_e] <= s_task;
            end
            OP_ACQ_RD: begin
              ent_rd[s_e]   <= ent_rd[s_e] + 1'b1;
              ent_cons[s_e] <= ent_cons[s_e] + 1'b1;
            end
            OP_REL: begin
              if (ent_wr[s_e] && ent_wtask[s_e] == s_task) ent_wr[s_e] <= 1'b0;
              else if (ent_rd[s_e] != '0) ent_rd[s_e] <= ent_rd[s_e] - 1'b1;
              else rsp_code <= RSP_NOT_HOLD;
            end
            OP_FREE: begin
              if (ent_cons[s_e] > CNTW'(1)) begin
                ent_cons[s_e] <= ent_cons[s_e] - 1'b1;
              end else begin
                ent_vld[s_e]             <= 1'b0;
                ent_wr[s_e]              <= 1'b0;
                ent_rd[s_e]              <= '0;
                page_used[ent_page[s_e]] <= 1'b0;
              end
            end
            default: rsp_code <= RSP_NO_ENTRY;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/buf_rights_chk.sv
module buf_rights_chk #(
  parameter int NREQ  = 4,
  parameter int NENT  = 16,
  parameter int NPAGE = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [NREQ-1:0]  req_valid,
  input logic [NREQ-1:0]  rsp_valid,
  input logic [NENT-1:0]  ent_vld,
  input logic [NENT-1:0]  ent_wr,
  input logic [NENT-1:0]  rd_busy,
  input logic [NPAGE-1:0] page_used
);
  AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rsp_valid)); // R8

  AST_WRITE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    (ent_wr & rd_busy) == '0); // R4

  AST_WRITER_LIVE_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (ent_wr & ~ent_vld) == '0); // R7

  AST_PAGE_PER_ENTRY: assert property (@(posedge clk) disable iff (rst)
    $countones(page_used) == $countones(ent_vld)); // R1

  for (genvar g = 0; g < NREQ; g++) begin : g_port
    AST_RESP_HAS_REQ: assert property (@(posedge clk) disable iff (rst)
      rsp_valid[g] |-> $past(req_valid[g])); // R10

    AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
      rsp_valid[g] |=> !rsp_valid[g]); // R10
  end
endmodule

bind buf_rights_mgr buf_rights_chk #(.NREQ(NREQ), .NENT(NENT), .NPAGE(NPAGE)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .req_valid(req_valid),
  .rsp_valid(rsp_valid),
  .ent_vld  (ent_vld),
  .ent_wr   (ent_wr),
  .rd_busy  (rd_busy),
  .page_used(page_used)
);

// File: tb/tb_buf_rights_mgr.sv
`timescale 1ns/1ps
module tb_buf_rights_mgr;
  localparam int NREQ = 4, TIDW = 8, DIDW = 8, PGW = 4;
  localparam int ALLOC = 0, WR = 1, RD = 2, REL = 3, FREE = 4;
  localparam int GRANT = 0, NOENT = 1, NOSPC = 2, NOTHLD = 3;

  logic clk = 1'b0, rst = 1'b1;
  always #2 clk = ~clk;

  logic [2:0]      b_op   [NREQ];
  logic [TIDW-1:0] b_task [NREQ];
  logic [DIDW-1:0] b_did  [NREQ];
  logic [NREQ-1:0] req_valid = '0;
  logic [3*NREQ-1:0]    req_op;
  logic [TIDW*NREQ-1:0] req_task;
  logic [DIDW*NREQ-1:0] req_did;
  logic [NREQ-1:0] rsp_valid;
  logic [1:0]      rsp_code;
  logic [PGW-1:0]  rsp_page;

  always_comb
    for (int i = 0; i < NREQ; i++) begin
      req_op[i*3 +: 3]        = b_op[i];
      req_task[i*TIDW +: TIDW] = b_task[i];
      req_did[i*DIDW +: DIDW]  = b_did[i];
    end

  buf_rights_mgr dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_task(req_task), .req_did(req_did), .rsp_valid(rsp_valid),
    .rsp_code(rsp_code), .rsp_page(rsp_page)
  );

  int checks = 0, errors = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_req(int p, int op, int tid, int did,
                        output int code, output int page, output int lat);
    b_op[p] = 3'(op); b_task[p] = TIDW'(tid); b_did[p] = DIDW'(did);
    req_valid[p] = 1'b1;
    lat = 0; code = -1; page = -1;
    while (lat < 2000) begin
      @(posedge clk); @(negedge clk);
      lat++;
      if (rsp_valid[p]) begin
        code = int'(rsp_code); page = int'(rsp_page);
        break;
      end
    end
    req_valid[p] = 1'b0;
    if (lat >= 2000) chk("timeout", lat, 0);
  endtask

  int c, pg, l, c2, pg2, l2, c3, pg3, l3;

  task automatic t_reset();
    chk("R9 no response after reset", int'(rsp_valid), 0);
    do_req(0, FREE, 1, 8'h05, c, pg, l);
    chk("R9 empty table free", c, NOENT);
    chk("R10 latency", l, 1);
    do_req(0, 7, 1, 8'h05, c, pg, l);
    chk("R3 undefined op", c, NOENT);
  endtask

  task automatic t_alloc();
    do_req(0, ALLOC, 1, 8'h10, c, pg, l);
    chk("R1 alloc code", c, GRANT); chk("R1 alloc page", pg, 0);
    do_req(1, ALLOC, 1, 8'h11, c, pg, l);
    chk("R1 alloc2 code", c, GRANT); chk("R1 alloc2 page", pg, 1);
    do_req(2, ALLOC, 4, 8'h10, c, pg, l);
    chk("R1 realloc code", c, GRANT); chk("R1 realloc page", pg, 0);
    do_req(0, RD, 1, 8'h33, c, pg, l);
    chk("R3 read unknown", c, NOENT);
  endtask

  task automatic t_write_block();
    do_req(0, WR, 2, 8'h10, c, pg, l);
    chk("R4 write grant", c, GRANT); chk("R10 write page", pg, 0);
    fork
      do_req(1, WR, 3, 8'h10, c2, pg2, l2);
      begin
        repeat (6) @(negedge clk);
        do_req(0, REL, 2, 8'h10, c3, pg3, l3);
      end
    join
    chk("R6 writer release", c3, GRANT);
    chk("R4 blocked write granted", c2, GRANT);
    chk("R4 write waited", int'(l2 > 7), 1);
    do_req(1, REL, 3, 8'h10, c, pg, l);
    chk("R6 second writer release", c, GRANT);
  endtask

  task automatic t_readers();
    fork
      do_req(0, RD, 5, 8'h11, c, pg, l);
      do_req(1, RD, 6, 8'h11, c2, pg2, l2);
    join
    chk("R5 reader a", c, GRANT); chk("R5 reader b", c2, GRANT);
    chk("R8 port0 first", l, 1); chk("R8 port1 second", l2, 2);
    fork
      do_req(2, WR, 7, 8'h11, c3, pg3, l3);
      begin
        repeat (3) @(negedge clk);
        do_req(0, REL, 5, 8'h11, c, pg, l);
        chk("R6 reader release", c, GRANT);
        repeat (3) @(negedge clk);
        do_req(1, REL, 6, 8'h11, c, pg, l);
      end
    join
    chk("R4 write after readers", c3, GRANT);
    chk("R4 waited for both readers", int'(l3 > 8), 1);
    do_req(3, REL, 9, 8'h11, c, pg, l);
    chk("R6 non-holder release", c, NOTHLD);
    do_req(3, REL, 7, 8'h11, c, pg, l);
    chk("R6 holder release", c, GRANT);
    do_req(3, REL, 7, 8'h11, c, pg, l);
    chk("R6 release without right", c, NOTHLD);
  endtask

  task automatic t_free();
    // consumers of 0x11: alloc 1 + two reads = 3
    do_req(0, FREE, 5, 8'h11, c, pg, l);
    chk("R7 free partial", c, GRANT);
    do_req(0, FREE, 6, 8'h11, c, pg, l);
    chk("R7 free partial 2", c, GRANT);
    do_req(1, WR, 1, 8'h11, c, pg, l);
    chk("R7 buffer still alive", c, GRANT); chk("R7 page kept", pg, 1);
    do_req(1, REL, 1, 8'h11, c, pg, l);
    do_req(2, FREE, 1, 8'h11, c, pg, l);
    chk("R7 last free", c, GRANT);
    do_req(2, RD, 1, 8'h11, c, pg, l);
    chk("R7 freed id gone", c, NOENT);
    do_req(3, ALLOC, 2, 8'h20, c, pg, l);
    chk("R7 page reused", pg, 1);
  endtask

  task automatic t_full();
    int bad = 0;
    for (int k = 0; k < 14; k++) begin
      do_req(k % NREQ, ALLOC, 3, 8'h40 + k, c, pg, l);
      if (c != GRANT || pg != k + 2) bad++;
    end
    chk("R1 fill pages in order", bad, 0);
    do_req(0, ALLOC, 3, 8'h60, c, pg, l);
    chk("R2 pool exhausted", c, NOSPC);
    do_req(1, ALLOC, 3, 8'h41, c, pg, l);
    chk("R1 existing id when full", c, GRANT); chk("R1 existing page when full", pg, 3);
  endtask

  task automatic t_priority();
    int c4, pg4, l4;
    do_req(0, WR, 5, 8'h10, c, pg, l);
    chk("R4 hold write", c, GRANT);
    fork
      do_req(0, WR, 6, 8'h10, c, pg, l);
      do_req(2, RD, 1, 8'h40, c2, pg2, l2);
      do_req(3, RD, 1, 8'h41, c3, pg3, l3);
      begin
        repeat (4) @(negedge clk);
        do_req(1, REL, 5, 8'h10, c4, pg4, l4);
      end
    join
    chk("R8 port2 not held back", l2, 1); chk("R8 port2 page", pg2, 2);
    chk("R8 port3 after port2", l3, 2); chk("R8 port3 page", pg3, 3);
    chk("R6 release", c4, GRANT);
    chk("R4 blocked write granted", c, GRANT);
    chk("R4 blocked write waited", int'(l > 5), 1);
    do_req(0, REL, 6, 8'h10, c, pg, l);
    chk("R6 final release", c, GRANT);
  endtask

  initial begin
    for (int i = 0; i < NREQ; i++) begin b_op[i] = '0; b_task[i] = '0; b_did[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    t_reset();
    t_alloc();
    t_write_block();
    t_readers();
    t_free();
    t_full();
    t_priority();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule